// File: doc/BRIEF.md
# Aligned Serial Shift Register

This block is the shift-register pair of a synchronous serial port. It sends a parallel word out one bit at a time, most significant bit first, and gathers incoming serial bits back into a parallel word. Both sides work on a 24-bit fractional data path. The block does not generate a bit clock. Instead, it is given single-cycle strobes that mark the rising and falling edges of an external bit clock, together with a strobe that marks the first bit of each word.

Words shorter than the register are left-justified. In wide alignment, the word's MSB sits at bit 23. In narrow alignment, which suits 16-bit fractional software, the MSB sits at bit 15. Narrow alignment only allows 8-, 12- and 16-bit words. Any other choice raises an error flag, and the block will not start a word while that flag is set. A 32-bit word in wide alignment keeps only its first 24 received bits.

Top module: `aligned_shift_pair`

## Requirements
- R1: Word-length codes on `wlen_sel` are 0=8, 1=12, 2=16, 3=24 and 4=32 bits. With `align15`=0, the transmitter sends `tx_word` MSB first, starting from bit 23, for the selected number of bits.
- R2: With `align15`=1, the transmitter sends bits 15 downward of `tx_word`, MSB first. Bits 23:16 of `tx_word` are never sent.
- R3: With `align15`=0 and a length of 24 or less, the received word has its first received bit at bit 23. All bits below the word are zero.
- R4: With `align15`=1, the received word has its first received bit at bit 15. Bits 23:16 are zero, and so are all bits below the word.
- R5: For a 32-bit word with `align15`=0, the received word holds the first 24 bits and the last 8 are discarded. The transmitter sends 8 zero bits after bit 0 of `tx_word`.
- R6: `sdout` changes only in the clock cycle after a `bclk_rise` strobe. `sdin` is sampled only on cycles where `bclk_fall` is high.
- R7: `rx_valid` is high for exactly one cycle, in the cycle after the `bclk_fall` that captures a word's last bit. `rx_word` takes its new value in that same cycle.
- R8: `len_err` goes high one cycle after an illegal setting appears. The illegal settings are: codes 5 to 7 in either alignment, and codes 3 or 4 with `align15`=1.
- R9: A `word_start` strobe given while the setting is illegal starts nothing: `sdout` stays 0 and no `rx_valid` follows.
- R10: Once the last bit of a word has been sent, the next `bclk_rise` without `word_start` drives `sdout` to 0.
- R11: Length and alignment are captured when a word starts. Changing `wlen_sel` or `align15` during a word does not affect that word.
- R12: A new word may start on the rise right after the previous word's last bit, with no idle bit between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_rise | input | 1 | Strobe marking a rising bit-clock edge |
| bclk_fall | input | 1 | Strobe marking a falling bit-clock edge |
| word_start | input | 1 | First-bit marker; only acted on together with `bclk_rise` |
| sdin | input | 1 | Serial receive data |
| tx_word | input | 24 | Parallel word to transmit, taken at word start |
| wlen_sel | input | 3 | Word-length code |
| align15 | input | 1 | 1 = narrow alignment (MSB at bit 15), 0 = wide alignment (MSB at bit 23) |
| sdout | output | 1 | Serial transmit data |
| rx_word | output | 24 | Last received word, aligned |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` updates |
| len_err | output | 1 | Illegal length/alignment combination |

## Verification
A bit counter that is off by one in either shifter shows at the ports within one word. The transmit stream gains or loses a bit, which the next rise after the word exposes through a nonzero `sdout`. On the receive side, `rx_valid` lands one bit period early or late and the aligned word comes out shifted. A wrong alignment shift amount puts nonzero data into bits 23:16, or below the word, on the first narrow or short word. A setting that was not captured at word start corrupts the word during which the inputs are scrambled.

// File: rtl/ass_pkg.sv
package ass_pkg;
    localparam int DATA_W   = 24;
    localparam int NARROW_W = 16;
    localparam int CNT_W    = 6;

    function automatic logic [CNT_W-1:0] code_bits(input logic [2:0] code);
        case (code)
            3'd0:    code_bits = CNT_W'(8);
            3'd1:    code_bits = CNT_W'(12);
            3'd2:    code_bits = CNT_W'(16);
            3'd3:    code_bits = CNT_W'(24);
            3'd4:    code_bits = CNT_W'(32);
            default: code_bits = CNT_W'(8);
        endcase
    endfunction

    function automatic logic code_legal(input logic [2:0] code, input logic narrow);
        if (code > 3'd4)
            code_legal = 1'b0;
        else if (narrow)
            code_legal = (code < 3'd3);
        else
            code_legal = 1'b1;
    endfunction
endpackage

// File: rtl/ass_len_decode.sv
module ass_len_decode
    import ass_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       wlen_sel,
    input  logic             align15,
    output logic [CNT_W-1:0] bit_len,
    output logic             legal,
    output logic             len_err
);
    typedef struct packed {
        logic err;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        bit_len  = code_bits(wlen_sel);
        legal    = code_legal(wlen_sel, align15);
        st_d     = st_q;
        st_d.err = ~legal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign len_err = st_q.err;

    a_r8_narrow_wide_err: assert property (@(posedge clk) disable iff (!rst_n)
        (align15 && (wlen_sel == 3'd3 || wlen_sel == 3'd4)) |=> len_err);
endmodule

// File: rtl/ass_tx_shift.sv
module ass_tx_shift
    import ass_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_rise,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              align15,
    input  logic [CNT_W-1:0]  bit_len,
    output logic              sdout
);
    localparam int PAD_W = DATA_W - NARROW_W;

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  left;
        logic              sd;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic [DATA_W-1:0] load_w;

    always_comb begin
        st_d   = st_q;
        load_w = align15 ? {tx_word[NARROW_W-1:0], {PAD_W{1'b0}}} : tx_word;
        if (bclk_rise) begin
            if (start) begin
                st_d.sd   = load_w[DATA_W-1];
                st_d.sh   = load_w << 1;
                st_d.left = bit_len - CNT_W'(1);
            end else if (st_q.left != '0) begin
                st_d.sd   = st_q.sh[DATA_W-1];
                st_d.sh   = st_q.sh << 1;
                st_d.left = st_q.left - CNT_W'(1);
            end else begin
                st_d.sd   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdout = st_q.sd;

    a_r6_sdout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_rise |=> $stable(sdout));
    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_rise && !start && st_q.left == '0) |=> !sdout);
endmodule

// File: rtl/ass_rx_shift.sv
module ass_rx_shift
    import ass_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_fall,
    input  logic              start,
    input  logic              sdin,
    input  logic              align15,
    input  logic [CNT_W-1:0]  bit_len,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_valid
);
    localparam logic [CNT_W-1:0] DW_C = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] NW_C = CNT_W'(NARROW_W);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  len;
        logic              nar;
        logic              active;
        logic              vld;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic [CNT_W-1:0]  keep;
    logic [CNT_W-1:0]  shamt;
    logic [DATA_W-1:0] sh_nx;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        keep     = (st_q.len > DW_C) ? DW_C : st_q.len;
        shamt    = st_q.nar ? (NW_C - st_q.len) : (DW_C - keep);
        sh_nx    = st_q.sh;
        if (st_q.cnt < keep)
            sh_nx = {st_q.sh[DATA_W-2:0], sdin};
        if (start) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.len    = bit_len;
            st_d.nar    = align15;
            st_d.sh     = '0;
        end else if (bclk_fall && st_q.active) begin
            st_d.sh  = sh_nx;
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == st_q.len - CNT_W'(1)) begin
                st_d.active = 1'b0;
                st_d.vld    = 1'b1;
                st_d.word   = sh_nx << shamt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_word  = st_q.word;
    assign rx_valid = st_q.vld;

    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    a_r7_word_changes_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !st_d.vld |=> $stable(rx_word));
    a_r4_narrow_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && st_q.nar) |-> (rx_word[DATA_W-1:NARROW_W] == '0));
endmodule

// File: rtl/aligned_shift_pair.sv
module aligned_shift_pair
    import ass_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              word_start,
    input  logic              sdin,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [2:0]        wlen_sel,
    input  logic              align15,
    output logic              sdout,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              len_err
);
    logic [CNT_W-1:0] bit_len;
    logic             legal;
    logic             start;

    assign start = bclk_rise & word_start & legal;

    ass_len_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wlen_sel (wlen_sel),
        .align15  (align15),
        .bit_len  (bit_len),
        .legal    (legal),
        .len_err  (len_err)
    );

    ass_tx_shift u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_rise (bclk_rise),
        .start     (start),
        .tx_word   (tx_word),
        .align15   (align15),
        .bit_len   (bit_len),
        .sdout     (sdout)
    );

    ass_rx_shift u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_fall (bclk_fall),
        .start     (start),
        .sdin      (sdin),
        .align15   (align15),
        .bit_len   (bit_len),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid)
    );

    a_r9_no_start_when_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_rise && word_start && !legal && !sdout && !u_rx.st_q.active) |=> (!sdout && !rx_valid));
endmodule

// File: tb/aligned_shift_pair_test.sv
module aligned_shift_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_rise = 1'b0, bclk_fall = 1'b0, word_start = 1'b0, sdin = 1'b0;
    logic [23:0] tx_word = '0;
    logic [2:0]  wlen_sel = '0;
    logic        align15 = 1'b0;
    logic        sdout, rx_valid, len_err;
    logic [23:0] rx_word;

    int checks = 0;
    int fails  = 0;
    logic [23:0] exp_q[$];
    string       req_q[$];

    always #2 clk = ~clk;

    aligned_shift_pair uut (
        .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .word_start(word_start), .sdin(sdin), .tx_word(tx_word), .wlen_sel(wlen_sel),
        .align15(align15), .sdout(sdout), .rx_word(rx_word), .rx_valid(rx_valid),
        .len_err(len_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each received-word strobe
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected rx_valid", {8'h0, rx_word}, 32'h0);
            end else begin
                logic [23:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(rx_word == e, r, {8'h0, rx_word}, {8'h0, e});
            end
        end
    end

    function automatic int len_of(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 24;
            default: return 32;
        endcase
    endfunction

    task automatic run_word(input logic [2:0] code, input logic nar, input logic [23:0] txw,
                            input logic [31:0] pat, input bit idle, input bit scramble,
                            input string req);
        int len;
        int keep;
        logic [23:0] v;
        logic [23:0] e;
        logic eb;
        len  = len_of(code);
        keep = (len > 24) ? 24 : len;
        v = '0;
        for (int i = 0; i < keep; i++) v = {v[22:0], pat[31-i]};
        e = nar ? (v << (16 - len)) : (v << (24 - keep));
        exp_q.push_back(e);
        req_q.push_back(req);
        wlen_sel = code;
        align15  = nar;
        tx_word  = txw;
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            bclk_rise  = 1'b1;
            word_start = (i == 0);
            sdin       = pat[31-i];
            @(negedge clk);
            bclk_rise  = 1'b0;
            word_start = 1'b0;
            if (scramble && i == 0) begin
                wlen_sel = 3'd7;
                align15  = ~nar;
            end
            eb = nar ? txw[15-i] : ((i < 24) ? txw[23-i] : 1'b0);
            check(sdout == eb, {req, " tx bit"}, {31'h0, sdout}, {31'h0, eb});
            @(negedge clk);
            bclk_fall = 1'b1;
            @(negedge clk);
            bclk_fall = 1'b0;
            @(negedge clk);
        end
        if (idle) begin
            bclk_rise = 1'b1;
            @(negedge clk);
            bclk_rise = 1'b0;
            check(sdout == 1'b0, "R10 idle after word", {31'h0, sdout}, 32'h0);
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic try_illegal(input logic [2:0] code, input logic nar);
        wlen_sel = code;
        align15  = nar;
        @(negedge clk);
        check(len_err == 1'b1, "R8 len_err raised", {31'h0, len_err}, 32'h1);
        for (int i = 0; i < 10; i++) begin
            bclk_rise  = 1'b1;
            word_start = (i == 0);
            sdin       = 1'b1;
            @(negedge clk);
            bclk_rise  = 1'b0;
            word_start = 1'b0;
            check(sdout == 1'b0, "R9 no transmit when illegal", {31'h0, sdout}, 32'h0);
            bclk_fall = 1'b1;
            @(negedge clk);
            bclk_fall = 1'b0;
            @(negedge clk);
        end
        wlen_sel = 3'd0;
        align15  = 1'b0;
        @(negedge clk);
        check(len_err == 1'b0, "R8 len_err cleared", {31'h0, len_err}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sdout == 1'b0,   "reset sdout", {31'h0, sdout}, 32'h0);
        check(rx_valid == 1'b0, "reset rx_valid", {31'h0, rx_valid}, 32'h0);
        check(rx_word == 24'h0, "reset rx_word", {8'h0, rx_word}, 32'h0);
        check(len_err == 1'b0, "reset len_err", {31'h0, len_err}, 32'h0);

        run_word(3'd3, 1'b0, 24'hA5C33C, 32'hDEADBE00, 1, 0, "R1 R3 24-bit wide");
        run_word(3'd0, 1'b0, 24'h96F0F0, 32'hC5000000, 1, 0, "R3 8-bit wide");
        run_word(3'd1, 1'b0, 24'h3E1777, 32'hB7D00000, 1, 0, "R3 12-bit wide");
        run_word(3'd4, 1'b0, 24'h5A5A5B, 32'h8123457F, 1, 0, "R5 32-bit discard");
        run_word(3'd2, 1'b1, 24'hFFB4C3, 32'hE1D20000, 1, 0, "R2 R4 16-bit narrow");
        run_word(3'd0, 1'b1, 24'hFFFF9D, 32'hA9000000, 1, 0, "R4 8-bit narrow");
        run_word(3'd1, 1'b1, 24'h12F6E1, 32'h6B100000, 1, 0, "R4 12-bit narrow");
        run_word(3'd1, 1'b0, 24'hC3A000, 32'h5E300000, 1, 1, "R11 settings scrambled mid-word");
        run_word(3'd0, 1'b0, 24'h81FFFF, 32'h7E000000, 0, 0, "R12 back-to-back first");
        run_word(3'd2, 1'b1, 24'h00ACE1, 32'h13570000, 1, 0, "R12 back-to-back second");
        try_illegal(3'd3, 1'b1);
        try_illegal(3'd4, 1'b1);
        try_illegal(3'd6, 1'b0);
        run_word(3'd3, 1'b0, 24'h000001, 32'hFFFFFF00, 1, 0, "R6 R7 after error recovery");

        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R7 every word strobed", exp_q.size(), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule